// File: doc/BRIEF.md
# Configurable Asynchronous Character Transmitter

This block turns single bytes written by a host into asynchronous serial characters on one output line. A format register sets the shape of each character: five to eight data bits, an optional parity bit of four kinds, and one or two stop bits. It also holds a break control that pulls the line low. Every character starts with a low start bit. Data bits go out least-significant first, and the line rests high between characters.

The host has one write port that reaches two destinations, chosen by a select input: the format register and the transmit byte. A byte written to the transmit destination waits in a single holding slot. It goes out at the next bit-rate tick once the serializer is free. An external enable pulse, `bit_tick`, sets the bit rate, and every bit on the line lasts exactly one tick interval. A busy flag covers each character from its start bit to its last stop bit.

Top module: `async_char_tx`

## Requirements
- R1: After reset, `txd` is 1 and `busy` is 0. The format resets to all zero, which gives 8 data bits, no parity, one stop bit and no break. While idle with break clear, `txd` stays 1.
- R2: A write with `wr_sel`=0 loads the format from `wr_data` with this layout: bit 6 break, bit 5 two-stop select, bits 4:3 parity kind, bit 2 parity enable, bits 1:0 length code. Bit 7 has no effect.
- R3: Each character is a start bit of 0 followed by the data bits, least-significant first. Length code 0 sends 8 data bits, 1 sends 7, 2 sends 6 and 3 sends 5. Byte bits above the selected length are not sent.
- R4: With parity enabled, the parity bit comes right after the last data bit. Kind 0 sends 0. Kind 1 makes the count of ones over data and parity odd. Kind 2 makes it even. Kind 3 sends 1.
- R5: With parity enable clear, no parity bit is sent and the stop bits follow the last data bit directly.
- R6: With the two-stop select set, two stop bits of 1 end the character. With it clear, one stop bit ends it.
- R7: A character starts only at a clock edge where `bit_tick` is high. Each later tick edge moves the line to the next bit, so every bit lasts one tick interval. `busy` is 1 from the start bit through the last stop bit.
- R8: A write with `wr_sel`=1 puts the byte in the holding slot. A byte that arrives while a character is in flight goes out right after the last stop bit, with no idle bit between and `busy` staying 1. A second such write before that point replaces the held byte.
- R9: While break is set, `txd` is 0 whether or not a character is in flight. Character timing carries on underneath. Clearing break gives the line back.
- R10: A character keeps the format that was in force when its start bit began. A format write during a character affects only later characters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the host port |
| wr_sel | input | 1 | Destination: 0 format register, 1 transmit byte |
| wr_data | input | 8 | Write data |
| bit_tick | input | 1 | One-cycle bit-rate enable pulse |
| txd | output | 1 | Serial output line, idle high |
| busy | output | 1 | High while a character is on the line |

## Verification
The hardest situation to reach from the ports is a held byte being replaced and then sent back to back. The first character has to be on the line already, so the slot is free for two more writes. Those writes must land before the last stop bit of that character. The stimulus waits for `busy` to rise, then writes twice within a few cycles. It expects only the second byte to follow, and it watches `busy` at every cycle until the stream drains. Format writes in the middle of a character are placed the same way to exercise the snapshot rule.

// File: rtl/cfgtx_pkg.sv
package cfgtx_pkg;

    localparam int MAX_DATA  = 8;
    localparam int MAX_STOP  = 2;
    localparam int FRAME_MAX = 1 + MAX_DATA + 1 + MAX_STOP;
    localparam int CNT_W     = $clog2(FRAME_MAX + 1);

    typedef enum logic {
        SEL_FORMAT = 1'b0,
        SEL_DATA   = 1'b1
    } reg_sel_e;

    typedef enum logic [1:0] {
        PAR_SPACE = 2'd0,
        PAR_ODD   = 2'd1,
        PAR_EVEN  = 2'd2,
        PAR_MARK  = 2'd3
    } par_kind_e;

    // Field order matches the bit positions of the format write.
    typedef struct packed {
        logic      brk;
        logic      two_stop;
        par_kind_e par_kind;
        logic      par_en;
        logic [1:0] len_code;
    } fmt_t;

    typedef struct packed {
        logic [FRAME_MAX-1:0] bits;
        logic [CNT_W-1:0]     count;
    } frame_t;

    function automatic int data_len(input logic [1:0] code);
        return MAX_DATA - int'(code);
    endfunction

    function automatic logic parity_of(input logic [MAX_DATA-1:0] data,
                                       input int n,
                                       input par_kind_e kind);
        logic acc;
        acc = 1'b0;
        for (int i = 0; i < MAX_DATA; i++) begin
            if (i < n) acc = acc ^ data[i];
        end
        case (kind)
            PAR_SPACE: return 1'b0;
            PAR_ODD:   return ~acc;
            PAR_EVEN:  return acc;
            default:   return 1'b1;
        endcase
    endfunction

    // Frame bits are LSB-first: start, data, optional parity, stop bits.
    function automatic frame_t build_frame(input logic [MAX_DATA-1:0] data,
                                           input fmt_t fmt);
        frame_t f;
        int n;
        int p_pos;
        logic pbit;
        n     = data_len(fmt.len_code);
        p_pos = 1 + n;
        pbit  = parity_of(data, n, fmt.par_kind);
        f.bits = '1;
        f.bits[0] = 1'b0;
        for (int i = 0; i < MAX_DATA; i++) begin
            if (i < n) f.bits[1 + i] = data[i];
        end
        for (int p = 0; p < FRAME_MAX; p++) begin
            if (fmt.par_en && p == p_pos) f.bits[p] = pbit;
        end
        f.count = CNT_W'(1 + n + (fmt.par_en ? 1 : 0) + (fmt.two_stop ? 2 : 1));
        return f;
    endfunction

endpackage

// File: rtl/cfgtx_fmt_reg.sv
module cfgtx_fmt_reg
    import cfgtx_pkg::*;
#(
    parameter int IN_W = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            we,
    input  logic [IN_W-1:0] din,
    output fmt_t            fmt_q
);
    localparam int FMT_W = $bits(fmt_t);

    logic [IN_W-FMT_W-1:0] unused_rsvd;
    assign unused_rsvd = din[IN_W-1:FMT_W];

    always_ff @(posedge clk) begin
        if (rst) begin
            fmt_q <= '0;
        end else if (we) begin
            fmt_q <= fmt_t'(din[FMT_W-1:0]);
        end
    end
endmodule

// File: rtl/cfgtx_hold_reg.sv
module cfgtx_hold_reg #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [DATA_W-1:0] din,
    input  logic              pop,
    output logic              valid,
    output logic [DATA_W-1:0] data
);
    always_ff @(posedge clk) begin
        if (rst) begin
            valid <= 1'b0;
            data  <= '0;
        end else begin
            if (we) begin
                valid <= 1'b1;
                data  <= din;
            end else if (pop) begin
                valid <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/cfgtx_frame_engine.sv
module cfgtx_frame_engine
    import cfgtx_pkg::*;
#(
    parameter int DATA_W = MAX_DATA
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              hold_valid,
    input  logic [DATA_W-1:0] hold_data,
    input  fmt_t              fmt,
    output logic              pop,
    output logic              busy,
    output logic              line_raw
);
    logic                 active;
    logic [FRAME_MAX-1:0] shreg;
    logic [CNT_W-1:0]     remain;
    logic                 last_bit;
    logic                 load;
    frame_t               next_frame;

    assign next_frame = build_frame(hold_data, fmt);
    assign last_bit   = active && (remain == CNT_W'(1));
    assign load       = tick && hold_valid && (!active || last_bit);
    assign pop        = load;

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b0;
            shreg  <= '1;
            remain <= '0;
        end else if (tick) begin
            if (load) begin
                active <= 1'b1;
                shreg  <= next_frame.bits;
                remain <= next_frame.count;
            end else if (active) begin
                if (last_bit) begin
                    active <= 1'b0;
                    shreg  <= '1;
                    remain <= '0;
                end else begin
                    shreg  <= {1'b1, shreg[FRAME_MAX-1:1]};
                    remain <= remain - CNT_W'(1);
                end
            end
        end
    end

    assign busy     = active;
    assign line_raw = active ? shreg[0] : 1'b1;
endmodule

// File: rtl/async_char_tx.sv
module async_char_tx
    import cfgtx_pkg::*;
#(
    parameter int DATA_W = MAX_DATA
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              bit_tick,
    output logic              txd,
    output logic              busy
);
    fmt_t              fmt_q;
    logic              hold_valid;
    logic [DATA_W-1:0] hold_data;
    logic              hold_pop;
    logic              line_raw;
    logic              brk_on;
    logic              fmt_we;
    logic              data_we;

    assign fmt_we  = wr_en && (reg_sel_e'(wr_sel) == SEL_FORMAT);
    assign data_we = wr_en && (reg_sel_e'(wr_sel) == SEL_DATA);

    cfgtx_fmt_reg #(.IN_W(DATA_W)) u_fmt (
        .clk   (clk),
        .rst   (rst),
        .we    (fmt_we),
        .din   (wr_data),
        .fmt_q (fmt_q)
    );

    cfgtx_hold_reg #(.DATA_W(DATA_W)) u_hold (
        .clk   (clk),
        .rst   (rst),
        .we    (data_we),
        .din   (wr_data),
        .pop   (hold_pop),
        .valid (hold_valid),
        .data  (hold_data)
    );

    cfgtx_frame_engine #(.DATA_W(DATA_W)) u_engine (
        .clk        (clk),
        .rst        (rst),
        .tick       (bit_tick),
        .hold_valid (hold_valid),
        .hold_data  (hold_data),
        .fmt        (fmt_q),
        .pop        (hold_pop),
        .busy       (busy),
        .line_raw   (line_raw)
    );

    assign brk_on = fmt_q.brk;
    assign txd    = brk_on ? 1'b0 : line_raw;
endmodule

// File: rtl/cfgtx_checker.sv
module cfgtx_checker (
    input logic clk,
    input logic rst,
    input logic bit_tick,
    input logic busy,
    input logic txd,
    input logic brk_on,
    input logic line_raw
);
    AST_IDLE_HIGH: assert property (@(posedge clk) disable iff (rst)
        (!busy && !brk_on) |-> txd) else $error("idle line not high"); // R1

    AST_BREAK_LOW: assert property (@(posedge clk) disable iff (rst)
        brk_on |-> !txd) else $error("break not forcing low"); // R9

    AST_START_ON_TICK: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(bit_tick)) else $error("start without tick"); // R7

    AST_START_BIT_LOW: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> !line_raw) else $error("start bit not low"); // R3

    AST_BIT_STABLE: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy) && !$past(bit_tick)) |-> $stable(line_raw))
        else $error("bit changed between ticks"); // R7

    AST_STOP_HIGH: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> $past(line_raw)) else $error("last bit not a stop"); // R6
endmodule

bind async_char_tx cfgtx_checker u_chk (
    .clk      (clk),
    .rst      (rst),
    .bit_tick (bit_tick),
    .busy     (busy),
    .txd      (txd),
    .brk_on   (brk_on),
    .line_raw (line_raw)
);

// File: tb/async_char_tx_test.sv
`timescale 1ns/1ps
module async_char_tx_test;
    localparam int TP = 4;

    typedef struct {
        logic  v;
        string tag;
    } exp_bit_t;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic       wr_sel = 1'b0;
    logic [7:0] wr_data = '0;
    logic       bit_tick = 1'b0;
    logic       txd;
    logic       busy;

    int checks = 0;
    int fails = 0;
    int tcnt = 0;
    int cyc = 0;
    bit run_mon = 1'b0;
    logic [6:0] fmt_cur = '0;
    exp_bit_t q[$];

    async_char_tx uut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .bit_tick(bit_tick), .txd(txd), .busy(busy)
    );

    always #2.5 clk = ~clk;

    task automatic check(input logic act, input logic exp, input string tag, input string what);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual=%0b expected=%0b at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    endtask

    // Independent frame model: push expected line bits for one character.
    function automatic void push_frame(input logic [7:0] d, input logic [6:0] f, input string tag);
        int n;
        logic acc;
        logic pb;
        exp_bit_t e;
        case (f[1:0])
            2'd0: n = 8;
            2'd1: n = 7;
            2'd2: n = 6;
            default: n = 5;
        endcase
        e.tag = tag;
        e.v = 1'b0; q.push_back(e);
        acc = 1'b0;
        for (int i = 0; i < n; i++) begin
            e.v = d[i]; q.push_back(e);
            acc = acc ^ d[i];
        end
        if (f[2]) begin
            case (f[4:3])
                2'd0: pb = 1'b0;
                2'd1: pb = ~acc;
                2'd2: pb = acc;
                default: pb = 1'b1;
            endcase
            e.v = pb; q.push_back(e);
        end
        e.v = 1'b1; q.push_back(e);
        if (f[5]) q.push_back(e);
    endfunction

    // Tick generator and line monitor: samples the bit just before each tick edge.
    always @(negedge clk) begin
        if (tcnt == TP - 1) begin
            tcnt = 0;
            bit_tick = 1'b1;
            if (run_mon) begin
                if (busy) begin
                    if (q.size() == 0) begin
                        check(1'b1, 1'b0, "R7", "busy with no expected bit");
                    end else begin
                        exp_bit_t e;
                        e = q.pop_front();
                        check(txd, fmt_cur[6] ? 1'b0 : e.v, fmt_cur[6] ? "R9" : e.tag, "line bit");
                    end
                end else begin
                    check(txd, fmt_cur[6] ? 1'b0 : 1'b1, fmt_cur[6] ? "R9" : "R1", "idle line");
                end
            end
        end else begin
            tcnt++;
            bit_tick = 1'b0;
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            summary();
        end
    end

    task automatic wr(input logic sel, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        @(posedge clk);
        if (!sel) fmt_cur = d[6:0];
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic send(input logic [7:0] d, input string tag);
        push_frame(d, fmt_cur, tag);
        wr(1'b1, d);
    endtask

    task automatic wait_busy();
        do @(negedge clk); while (!busy);
    endtask

    task automatic drain();
        do @(negedge clk); while (q.size() != 0 || busy);
        repeat (3) @(negedge clk);
    endtask

    task automatic watch_continuous(input string tag);
        while (q.size() != 0) begin
            @(negedge clk);
            if (q.size() != 0) check(busy, 1'b1, tag, "busy gap between characters");
        end
        drain();
    endtask

    initial begin
        void'($urandom(32'd4242));
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(txd, 1'b1, "R1", "reset txd");
        check(busy, 1'b0, "R1", "reset busy");
        run_mon = 1'b1;

        // R1/R3: reset format is 8N1
        send(8'hA5, "R3");
        drain();

        // R2: bit 7 ignored, otherwise 8N1
        wr(1'b0, 8'h80);
        send(8'h3C, "R2");
        drain();

        // R3: bits above length not sent (5 bits, no parity)
        wr(1'b0, 8'h03);
        send(8'hE0, "R3");
        drain();

        // R4: each parity kind, 7 bits
        for (int k = 0; k < 4; k++) begin
            wr(1'b0, 8'(8'h05 | (k << 3)));
            send(8'h31, "R4");
            send(8'h00, "R4");
            drain();
        end

        // R5/R6: no parity, two stop bits, 6 bits
        wr(1'b0, 8'h22);
        send(8'h2B, "R6");
        drain();
        wr(1'b0, 8'h02);
        send(8'h15, "R5");
        drain();

        // R8: replacement of held byte and back-to-back output
        wr(1'b0, 8'h0D);
        send(8'h5A, "R8");
        wait_busy();
        wr(1'b1, 8'hFF);
        send(8'h81, "R8");
        watch_continuous("R8");

        // R10: format change mid-character
        wr(1'b0, 8'h00);
        send(8'hC3, "R10");
        wait_busy();
        wr(1'b0, 8'h37);
        send(8'h1E, "R10");
        watch_continuous("R10");

        // R9: break holds line low during a character, then released
        wr(1'b0, 8'h40);
        send(8'h55, "R9");
        drain();
        wr(1'b0, 8'h00);
        @(negedge clk);
        check(txd, 1'b1, "R9", "line after break release");
        check(busy, 1'b0, "R9", "busy after break character");

        // Random formats and data
        for (int it = 0; it < 50; it++) begin
            logic [7:0] f;
            f = 8'($urandom) & 8'hBF;
            wr(1'b0, f);
            send(8'($urandom), "R3");
            if ($urandom % 2 == 1) begin
                wait_busy();
                send(8'($urandom), "R8");
                watch_continuous("R8");
            end else begin
                drain();
            end
            repeat ($urandom % 7) @(negedge clk);
        end

        drain();
        check(logic'(q.size() == 0), 1'b1, "R7", "all expected bits sent");
        summary();
    end
endmodule